// File: doc/BRIEF.md
# Multi-Channel Timer PWM Generator

This block turns a free-running timer counter into a set of pulse-width-modulated outputs. Four match registers sit on a small register bus. Software marks one or more of them with a reset-on-match bit. The lowest-numbered marked channel then defines the cycle length. When the counter reaches the last tick of that cycle, the block raises a clear request to the counter. Every other channel whose PWM enable bit is set drives its output pin. The pin is low at the start of each cycle and turns high once the counter reaches that channel's threshold.

The counter itself lives in the surrounding timer. The block receives its value, its enable and its synchronous clear. It returns the clear request and a one-clock cycle-start strobe. Thresholds and the period are copied into shadow registers at every cycle start, so a write made mid-cycle never cuts a pulse short. A channel whose PWM enable bit is clear passes the timer's ordinary external-match level straight to its pin. The `NUM_OUT` parameter (2 or 4) sets how many channels have a pin.

Top module: `mtpwm_gen`

## Requirements
- R1: After reset, every pin driven by PWM logic is low, `cyc_stb` and `cnt_clr` are low, and every register reads zero.
- R2: The register map is as follows. Match values sit at addresses 0 to 3, in the low `CNT_W` bits. The reset-on-match mask is at address 4, bits 3:0, with bit i for channel i. The PWM enable mask is at address 5, bits 3:0, with bit i for channel i. Status is at address 6, bit 0. Address 7 reads zero. All bits outside these fields read zero.
- R3: The period channel is the lowest-indexed channel with its reset-on-match bit set. `cnt_clr` is high exactly when the timer is enabled, not being cleared, the period is valid and `tmr_cnt` equals period-1. A cycle therefore lasts `period` ticks.
- R4: A PWM-driven output shows the level for the counter value of the previous clock. The level is high when the count is at least the threshold and below the period. A threshold of 0 gives a constant high. A threshold equal to or above the period gives a constant low.
- R5: A match value written during a cycle takes effect only from the next cycle start.
- R6: The period channel's own PWM output stays low. `cyc_stb` is high for one clock, aligned with the outputs for count 0. Consecutive strobes are `period` clocks apart.
- R7: When a channel's PWM enable bit is 0, its pin follows `ext_match` for that channel combinationally.
- R8: Status bit 0 is 1 when any PWM enable bit is set and either no channel has reset-on-match set or the period channel's match value is 0. While the active period is zero, PWM outputs are low and neither `cyc_stb` nor `cnt_clr` asserts.
- R9: While `tmr_en` is low, PWM outputs hold their levels, and `cyc_stb` and `cnt_clr` stay low.
- R10: A `tmr_clr` clock forces PWM outputs and `cyc_stb` low on the next clock. Counting resumes from zero with a strobe once the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tmr_en | input | 1 | Timer enable; the counter advances while high |
| tmr_clr | input | 1 | Synchronous timer clear |
| tmr_cnt | input | CNT_W | Current counter value |
| ext_match | input | NUM_OUT | Ordinary external-match levels, used where PWM is off |
| pwm_o | output | NUM_OUT | Output pins |
| cyc_stb | output | 1 | One-clock strobe at each cycle start |
| cnt_clr | output | 1 | Request to clear the counter on the next clock |

## Verification
Several properties are checked on every clock in every test:
- `cnt_clr` only while the timer runs;
- strobes only after a zero count seen with the timer enabled;
- outputs frozen while paused;
- outputs forced low after a clear;
- constant high for a zero threshold;
- no clear request without a valid period.

Only the directed scenarios can show the following:
- the exact duty position of each channel over a whole cycle;
- the period-channel priority;
- the delay of a threshold written mid-cycle to the next cycle;
- the error flag for a zero period;
- the external-match pass-through.

// File: rtl/mtpwm_pkg.sv
package mtpwm_pkg;
  localparam int N_MATCH = 4;
  localparam int IDX_W   = $clog2(N_MATCH);
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_RSTMSK = 3'd4;
  localparam logic [ADDR_W-1:0] A_PWMEN  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;
endpackage

// File: rtl/mtpwm_persel.sv
module mtpwm_persel
  import mtpwm_pkg::*;
(
  input  logic [N_MATCH-1:0] rst_mask,
  output logic               has_per,
  output logic [IDX_W-1:0]   per_idx
);
  // Lowest index with reset-on-match wins.
  always_comb begin
    has_per = |rst_mask;
    per_idx = '0;
    for (int i = N_MATCH - 1; i >= 0; i--) begin
      if (rst_mask[i]) per_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mtpwm_regs.sv
module mtpwm_regs
  import mtpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_OUT = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  input  logic                            has_per,
  input  logic [IDX_W-1:0]                per_idx,
  output logic [N_MATCH-1:0][CNT_W-1:0]   match_o,
  output logic [N_MATCH-1:0]              rst_mask_o,
  output logic [NUM_OUT-1:0]              pwm_en_o,
  output logic                            err_o
);
  localparam logic [N_MATCH-1:0] OUT_MASK = N_MATCH'((1 << NUM_OUT) - 1);

  logic [N_MATCH-1:0][CNT_W-1:0] m_q, m_d;
  logic [N_MATCH-1:0]            msk_q, msk_d;
  logic [N_MATCH-1:0]            en_q, en_d;

  always_comb begin
    m_d   = m_q;
    msk_d = msk_q;
    en_d  = en_q;
    if (we) begin
      if (!addr[2]) begin
        m_d[addr[IDX_W-1:0]] = wdata[CNT_W-1:0];
      end else if (addr == A_RSTMSK) begin
        msk_d = wdata[N_MATCH-1:0];
      end else if (addr == A_PWMEN) begin
        en_d = wdata[N_MATCH-1:0] & OUT_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      msk_q <= '0;
      en_q  <= '0;
    end else begin
      m_q   <= m_d;
      msk_q <= msk_d;
      en_q  <= en_d;
    end
  end

  assign err_o = (|en_q) && !(has_per && (m_q[per_idx] != '0));

  always_comb begin
    rdata = '0;
    if (!addr[2]) begin
      rdata[CNT_W-1:0] = m_q[addr[IDX_W-1:0]];
    end else if (addr == A_RSTMSK) begin
      rdata[N_MATCH-1:0] = msk_q;
    end else if (addr == A_PWMEN) begin
      rdata[N_MATCH-1:0] = en_q;
    end else if (addr == A_STAT) begin
      rdata[0] = err_o;
    end
  end

  assign match_o    = m_q;
  assign rst_mask_o = msk_q;
  assign pwm_en_o   = en_q[NUM_OUT-1:0];
endmodule

// File: rtl/mtpwm_shadow.sv
module mtpwm_shadow
  import mtpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [N_MATCH-1:0][CNT_W-1:0] match_i,
  output logic [N_MATCH-1:0][CNT_W-1:0] eff_o
);
  logic [N_MATCH-1:0][CNT_W-1:0] sh_q, sh_d;

  // On a load cycle the new values already govern the count-0 compare.
  always_comb begin
    sh_d  = load ? match_i : sh_q;
    eff_o = sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/mtpwm_chan.sv
module mtpwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             run_ok,
  input  logic             is_per,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic [CNT_W-1:0] per,
  input  logic             sel_pwm,
  input  logic             ext,
  output logic             lvl_q,
  output logic             out
);
  logic lvl, lvl_d;

  always_comb begin
    lvl = run_ok && !is_per && (cnt >= thr) && (cnt < per);
    if (clr)      lvl_d = 1'b0;
    else if (adv) lvl_d = lvl;
    else          lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign out = sel_pwm ? lvl_q : ext;
endmodule

// File: rtl/mtpwm_gen.sv
module mtpwm_gen
  import mtpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               tmr_en,
  input  logic               tmr_clr,
  input  logic [CNT_W-1:0]   tmr_cnt,
  input  logic [NUM_OUT-1:0] ext_match,
  output logic [NUM_OUT-1:0] pwm_o,
  output logic               cyc_stb,
  output logic               cnt_clr
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [N_MATCH-1:0][CNT_W-1:0] match_r, eff_m;
  logic [N_MATCH-1:0]            rst_mask;
  logic [NUM_OUT-1:0]            pwm_en;
  logic [NUM_OUT-1:0]            pwm_q;
  logic                          has_per, err, run_ok, load;
  logic [IDX_W-1:0]              per_idx;
  logic [CNT_W-1:0]              eff_per;
  logic                          stb_q, stb_d;

  mtpwm_persel u_sel (
    .rst_mask (rst_mask),
    .has_per  (has_per),
    .per_idx  (per_idx)
  );

  mtpwm_regs #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .has_per    (has_per),
    .per_idx    (per_idx),
    .match_o    (match_r),
    .rst_mask_o (rst_mask),
    .pwm_en_o   (pwm_en),
    .err_o      (err)
  );

  assign load = tmr_en && (tmr_cnt == '0);

  mtpwm_shadow #(.CNT_W(CNT_W)) u_shd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .match_i (match_r),
    .eff_o   (eff_m)
  );

  assign eff_per = eff_m[per_idx];
  assign run_ok  = has_per && (eff_per != '0);
  assign cnt_clr = tmr_en && !tmr_clr && run_ok && (tmr_cnt == (eff_per - 1'b1));

  always_comb begin
    if (tmr_clr) stb_d = 1'b0;
    else         stb_d = load && run_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stb_q <= 1'b0;
    else             stb_q <= stb_d;
  end
  assign cyc_stb = stb_q;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
    mtpwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr     (tmr_clr),
      .adv     (tmr_en),
      .run_ok  (run_ok),
      .is_per  (has_per && (per_idx == IDX_W'(g))),
      .cnt     (tmr_cnt),
      .thr     (eff_m[g]),
      .per     (eff_per),
      .sel_pwm (pwm_en[g]),
      .ext     (ext_match[g]),
      .lvl_q   (pwm_q[g]),
      .out     (pwm_o[g])
    );
  end
endmodule

// File: rtl/mtpwm_chk.sv
module mtpwm_chk
  import mtpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_OUT = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tmr_en,
  input logic                          tmr_clr,
  input logic [CNT_W-1:0]              tmr_cnt,
  input logic                          cnt_clr,
  input logic                          cyc_stb,
  input logic [NUM_OUT-1:0]            pwm_q,
  input logic                          run_ok,
  input logic                          has_per,
  input logic [IDX_W-1:0]              per_idx,
  input logic [N_MATCH-1:0][CNT_W-1:0] eff_m
);
  a_r3_clr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> (tmr_en && !tmr_clr));

  a_r6_stb_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |-> ($past(tmr_cnt) == '0 && $past(tmr_en)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !tmr_clr) |=> $stable(pwm_q));

  a_r9_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !cyc_stb);

  a_r10_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> (pwm_q == '0 && !cyc_stb));

  a_r8_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |-> !cnt_clr);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_a
    a_r4_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && !tmr_clr && run_ok && eff_m[g] == '0 &&
       !(has_per && per_idx == IDX_W'(g))) |=> pwm_q[g]);
  end
endmodule

bind mtpwm_gen mtpwm_chk #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tmr_en  (tmr_en),
  .tmr_clr (tmr_clr),
  .tmr_cnt (tmr_cnt),
  .cnt_clr (cnt_clr),
  .cyc_stb (cyc_stb),
  .pwm_q   (pwm_q),
  .run_ok  (run_ok),
  .has_per (has_per),
  .per_idx (per_idx),
  .eff_m   (eff_m)
);

// File: tb/test_mtpwm_gen.sv
module test_mtpwm_gen;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W = 16;
  localparam int NOUT  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             tmr_en = 1'b0;
  logic             tmr_clr = 1'b0;
  logic [CNT_W-1:0] tmr_cnt;
  logic [NOUT-1:0]  ext_match = '0;
  logic [NOUT-1:0]  pwm_o;
  logic             cyc_stb, cnt_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5ns clk = ~clk;

  // Timer counter model: clears on request or on a timer clear.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmr_cnt <= '0;
    else if (tmr_clr) tmr_cnt <= '0;
    else if (tmr_en)  tmr_cnt <= cnt_clr ? '0 : tmr_cnt + 1'b1;
  end

  mtpwm_gen #(.CNT_W(CNT_W), .NUM_OUT(NOUT)) i_mtpwm_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_en(tmr_en),
    .tmr_clr(tmr_clr), .tmr_cnt(tmr_cnt), .ext_match(ext_match),
    .pwm_o(pwm_o), .cyc_stb(cyc_stb), .cnt_clr(cnt_clr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic stop_timer();
    @(negedge clk);
    tmr_en = 1'b0; tmr_clr = 1'b1;
    @(negedge clk);
    tmr_clr = 1'b0;
  endtask

  task automatic start_timer();
    @(negedge clk);
    tmr_en = 1'b1;
  endtask

  task automatic wait_stb(input string req);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (cyc_stb) break;
    end
    check(cyc_stb == 1'b1, req, {31'd0, cyc_stb}, 32'd1);
  endtask

  function automatic bit exp_bit(input int c, input int j, input int p, input int m[4],
                                 input int per_ch, input logic [3:0] en);
    if (!en[c]) return ext_match[c];
    if (c == per_ch) return 1'b0;
    return (j >= m[c]) && (j < p);
  endfunction

  // One full cycle: per-channel waveform, strobe width and strobe spacing.
  task automatic chk_cycle(input int p, input int m[4], input int per_ch, input logic [3:0] en, input string req);
    int bad[4];
    int stb_bad;
    logic [3:0] first_bad;
    bad = '{0, 0, 0, 0};
    stb_bad = 0;
    first_bad = '0;
    wait_stb(req);
    for (int j = 0; j < p; j++) begin
      if (j > 0) @(negedge clk);
      for (int c = 0; c < NOUT; c++) begin
        if (pwm_o[c] != exp_bit(c, j, p, m, per_ch, en)) begin
          if (bad[c] == 0) first_bad[c] = pwm_o[c];
          bad[c]++;
        end
      end
      if (j > 0 && cyc_stb) stb_bad++;
    end
    for (int c = 0; c < NOUT; c++)
      check(bad[c] == 0, $sformatf("%s ch%0d waveform (mismatch clocks)", req, c), bad[c], 0);
    check(stb_bad == 0, {req, " R6 strobe width"}, stb_bad, 0);
    @(negedge clk);
    check(cyc_stb == 1'b1, {req, " R6 strobe spacing"}, {31'd0, cyc_stb}, 32'd1);
  endtask

  task automatic t_reset();
    check(pwm_o == '0, "R1 pwm_o", pwm_o, 0);
    check(cyc_stb == 1'b0, "R1 cyc_stb", cyc_stb, 0);
    check(cnt_clr == 1'b0, "R1 cnt_clr", cnt_clr, 0);
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 32'd0, "R1 register zero");
  endtask

  task automatic t_regmap();
    wr(3'd0, 32'h1234_ABCD);
    rd_chk(3'd0, 32'h0000_ABCD, "R2 match field");
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk(3'd4, 32'h0000_000F, "R2 reset mask field");
    wr(3'd5, 32'hFFFF_FFF0);
    rd_chk(3'd5, 32'h0000_0000, "R2 enable field low");
    rd_chk(3'd7, 32'd0, "R2 unused address");
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_basic();
    int m[4];
    m = '{3, 0, 10, 10};
    wr(3'd0, 3); wr(3'd1, 0); wr(3'd2, 10); wr(3'd3, 10);
    wr(3'd4, 32'h8);
    wr(3'd5, 32'hF);
    @(negedge clk);
    check(pwm_o == '0, "R9 configured but stopped", pwm_o, 0);
    start_timer();
    chk_cycle(10, m, 3, 4'hF, "R4 R3 basic");
    chk_cycle(10, m, 3, 4'hF, "R4 R6 basic repeat");
  endtask

  task automatic t_shadow();
    int bad = 0;
    int m[4];
    m = '{7, 0, 10, 10};
    wait_stb("R5 sync");
    for (int j = 0; j < 10; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 2) begin reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd7; end
      if (j == 3) reg_we = 1'b0;
      if (pwm_o[0] != (j >= 3)) bad++;
    end
    check(bad == 0, "R5 old threshold kept for current cycle", bad, 0);
    chk_cycle(10, m, 3, 4'hF, "R5 new threshold next cycle");
  endtask

  task automatic t_pause();
    logic [3:0] snap;
    int bad = 0;
    wait_stb("R9 sync");
    repeat (3) @(negedge clk);
    tmr_en = 1'b0;
    snap = pwm_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pwm_o != snap || cyc_stb || cnt_clr) bad++;
    end
    check(bad == 0, "R9 paused outputs hold", bad, 0);
    check(snap == 4'b0010, "R9 paused levels", snap, 4'b0010);
    tmr_en = 1'b1;
  endtask

  task automatic t_clear();
    wait_stb("R10 sync");
    repeat (4) @(negedge clk);
    tmr_clr = 1'b1;
    @(negedge clk);
    check(pwm_o == '0, "R10 outputs low after clear", pwm_o, 0);
    check(cyc_stb == 1'b0, "R10 strobe low after clear", cyc_stb, 0);
    tmr_clr = 1'b0;
    @(negedge clk);
    check(cyc_stb == 1'b1, "R10 restart strobe", cyc_stb, 1);
  endtask

  task automatic t_passthru();
    wr(3'd5, 32'hB);
    @(negedge clk);
    ext_match[2] = 1'b1;
    #1;
    check(pwm_o[2] == 1'b1, "R7 pass-through high", pwm_o[2], 1);
    ext_match[2] = 1'b0;
    #1;
    check(pwm_o[2] == 1'b0, "R7 pass-through low", pwm_o[2], 0);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_priority();
    int m[4];
    m = '{3, 6, 10, 10};
    stop_timer();
    wr(3'd0, 3); wr(3'd1, 6);
    wr(3'd4, 32'hA);
    start_timer();
    chk_cycle(6, m, 1, 4'hF, "R3 lowest reset channel is period");
  endtask

  task automatic t_zero_period();
    int bad = 0;
    stop_timer();
    wr(3'd4, 32'h8);
    wr(3'd3, 0);
    rd_chk(3'd6, 32'd1, "R8 error status set");
    start_timer();
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pwm_o != '0 || cyc_stb || cnt_clr) bad++;
    end
    check(bad == 0, "R8 zero period keeps PWM idle", bad, 0);
    stop_timer();
    wr(3'd3, 10);
    rd_chk(3'd6, 32'd0, "R8 error status clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_shadow();
    t_pause();
    t_clear();
    t_passthru();
    t_priority();
    t_zero_period();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule